// File: doc/BRIEF.md
# Biphase Mark Line Receiver with Preamble Hunt

This block recovers data from a Biphase Mark Coded line. A comparator output drives it. Each filtered transition, rising or falling, is stamped with a free-running counter, which advances only on cycles where the capture enable is high. The difference between two stamps, taken modulo the counter width, gives the length of one level on the line. The block classifies that length against a midpoint threshold as a half bit cell (short) or a whole bit cell (long).

While armed and hunting, the block shifts one flag per interval into a 32-bit search register. The flag is 1 for short and 0 for long. The register is compared with three fixed signatures: end of preamble, hard reset and cable reset. When the end of preamble is found, the block switches to decoding. A long interval yields a 0, two short intervals in a row yield a 1, and each bit is strobed out and also shifted into a 32-bit word. Malformed intervals, or a receive time limit reached during decoding, send the block back to hunting.

Symbol decoding, CRC and message parsing belong to downstream logic.

Top module: `bmc_edge_rx`

## Requirements
- R1: `line_in` is sampled only on capture ticks, and a new level is accepted only once two consecutive tick samples agree. A pulse lasting a single tick is never seen as an edge.
- R2: An interval is the number of capture ticks between two accepted edges of either polarity, computed modulo 2^TS_W. Cycles with `tick_en` low do not count.
- R3: An interval of 1 to SHORT_MAX (6) ticks is short. An interval of SHORT_MAX+1 to LONG_MAX (7 to 12) ticks is long.
- R4: While decoding, one long interval produces a bit of value 0, and two successive short intervals produce one bit of value 1. Each bit is reported by a single-cycle `bit_valid` with its value on `bit_value`.
- R5: While decoding, a short interval followed by a long one raises `rx_error` for one cycle, emits no bit and returns the block to hunting.
- R6: While decoding, an interval of 0 ticks (including exactly 2^TS_W ticks) or above LONG_MAX ticks raises `rx_error` for one cycle and returns the block to hunting.
- R7: Each decoded bit enters `bit_word` at bit 31 while the older bits move toward bit 0. After the 8 bits of a byte sent least significant first, `bit_word[31:24]` equals that byte. `bit_word` is cleared when sync is found.
- R8: While hunting, a search register built from the last 32 interval flags (newest at bit 31, short = 1) equal to 0x36DB6DB6 pulses `sync_found` for one cycle, and decoding starts with the next interval.
- R9: A search value of 0xF33F3F3F pulses `hard_reset` for one cycle. The block keeps hunting and can still find sync afterwards.
- R10: A search value of 0x3C7FE0FF pulses `cable_reset` for one cycle. The block keeps hunting.
- R11: RX_LIMIT capture ticks after sync is found, if decoding is still active, `rx_timeout` pulses for one cycle and the block returns to hunting.
- R12: While `arm` is low, edges are ignored. No output pulse appears and `bit_word` does not change.
- R13: After an error or a timeout, a fresh preamble end is detected again and the following bits decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Capture tick enable; the counter and line sampler advance on these cycles |
| arm | input | 1 | High enables hunting and decoding; low idles the receiver |
| line_in | input | 1 | Comparator output of the line |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_value | output | 1 | Value of the decoded bit |
| bit_word | output | WORD_W | Shift word of decoded bits, newest at the top |
| sync_found | output | 1 | One-cycle pulse when the preamble end signature matches |
| hard_reset | output | 1 | One-cycle pulse when the hard reset signature matches |
| cable_reset | output | 1 | One-cycle pulse when the cable reset signature matches |
| rx_error | output | 1 | One-cycle pulse on a malformed interval while decoding |
| rx_timeout | output | 1 | One-cycle pulse when the receive time limit expires |

## Verification
Each of the three signatures is played as a run of 4-tick and 8-tick levels. Each run must raise only its own pulse, and hunting must continue after a reset signature. Mixed 0 and 1 bytes check bit polarity and the order within the word. Levels of 6, 7, 12 and 13 ticks, a 256-tick level that wraps to zero, and a short followed by a long separate the two classes from each other and from an error. Further runs check single-tick glitches, a halved tick rate, a silent line reaching the timeout, and a full frame sent while disarmed.

// File: rtl/bmc_rx_pkg.sv
package bmc_rx_pkg;

    localparam int SRCH_W    = 32;
    localparam int NUM_SIGS  = 3;
    localparam int HIT_SYNC  = 0;
    localparam int HIT_HARD  = 1;
    localparam int HIT_CABLE = 2;

    // Search signatures, newest interval flag at bit 31
    localparam logic [SRCH_W-1:0] HUNT_SIGS [NUM_SIGS] = '{
        32'h36DB6DB6,
        32'hF33F3F3F,
        32'h3C7FE0FF
    };

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DATA
    } rx_state_e;

    typedef enum logic [1:0] {
        IV_BAD,
        IV_SHORT,
        IV_LONG
    } iv_class_e;

    typedef struct packed {
        logic valid;
        logic value;
    } bit_evt_t;

    function automatic iv_class_e classify_iv(input int unsigned ticks,
                                              input int unsigned short_max,
                                              input int unsigned long_max);
        if (ticks == 0 || ticks > long_max) return IV_BAD;
        if (ticks <= short_max)             return IV_SHORT;
        return IV_LONG;
    endfunction

endpackage

// File: rtl/bmc_rx_edge_stamp.sv
module bmc_rx_edge_stamp #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_en,
    input  logic            line_in,
    input  logic            stamp_clr,
    output logic            iv_valid,
    output logic [TS_W-1:0] iv_ticks
);

    logic            samp_q;
    logic            filt_q;
    logic            has_ts_q;
    logic [TS_W-1:0] tick_cnt_q;
    logic [TS_W-1:0] last_ts_q;
    logic            filt_nx;
    logic            edge_hit;

    // level accepted when two consecutive tick samples agree
    assign filt_nx  = (line_in == samp_q) ? line_in : filt_q;
    assign edge_hit = tick_en && (filt_nx != filt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q     <= 1'b0;
            filt_q     <= 1'b0;
            has_ts_q   <= 1'b0;
            tick_cnt_q <= '0;
            last_ts_q  <= '0;
            iv_valid   <= 1'b0;
            iv_ticks   <= '0;
        end else begin
            iv_valid <= 1'b0;
            if (tick_en) begin
                samp_q     <= line_in;
                filt_q     <= filt_nx;
                tick_cnt_q <= tick_cnt_q + 1'b1;
            end
            if (edge_hit) begin
                last_ts_q <= tick_cnt_q;
                has_ts_q  <= 1'b1;
                iv_valid  <= has_ts_q && !stamp_clr;
                iv_ticks  <= tick_cnt_q - last_ts_q;
            end
            if (stamp_clr) has_ts_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bmc_rx_hunt.sv
module bmc_rx_hunt
    import bmc_rx_pkg::*;
#(
    parameter int TS_W      = 8,
    parameter int SHORT_MAX = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                iv_valid,
    input  logic [TS_W-1:0]     iv_ticks,
    output logic [NUM_SIGS-1:0] hit
);

    logic [SRCH_W-1:0]   srch_q;
    logic [SRCH_W-1:0]   srch_nx;
    logic [NUM_SIGS-1:0] match;
    logic                is_short;

    assign is_short = (int'(iv_ticks) <= SHORT_MAX);
    assign srch_nx  = {is_short, srch_q[SRCH_W-1:1]};

    for (genvar k = 0; k < NUM_SIGS; k++) begin : g_sig
        assign match[k] = (srch_nx == HUNT_SIGS[k]);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            srch_q <= '0;
            hit    <= '0;
        end else begin
            hit <= '0;
            if (iv_valid) begin
                srch_q <= srch_nx;
                hit    <= match;
            end
        end
    end

endmodule

// File: rtl/bmc_rx_bitdec.sv
module bmc_rx_bitdec
    import bmc_rx_pkg::*;
#(
    parameter int TS_W      = 8,
    parameter int SHORT_MAX = 6,
    parameter int LONG_MAX  = 12,
    parameter int WORD_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              word_clr,
    input  logic              iv_valid,
    input  logic [TS_W-1:0]   iv_ticks,
    output bit_evt_t          evt,
    output logic [WORD_W-1:0] word,
    output logic              stream_err
);

    logic      half_q;
    iv_class_e cls;

    assign cls = classify_iv(int'(iv_ticks), SHORT_MAX, LONG_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q     <= 1'b0;
            evt        <= '0;
            word       <= '0;
            stream_err <= 1'b0;
        end else begin
            evt        <= '0;
            stream_err <= 1'b0;
            if (word_clr) word <= '0;
            if (clr) begin
                half_q <= 1'b0;
            end else if (iv_valid) begin
                unique case (cls)
                    IV_SHORT: begin
                        if (half_q) begin
                            half_q    <= 1'b0;
                            evt.valid <= 1'b1;
                            evt.value <= 1'b1;
                            word      <= {1'b1, word[WORD_W-1:1]};
                        end else begin
                            half_q <= 1'b1;
                        end
                    end
                    IV_LONG: begin
                        if (half_q) begin
                            half_q     <= 1'b0;
                            stream_err <= 1'b1;
                        end else begin
                            evt.valid <= 1'b1;
                            evt.value <= 1'b0;
                            word      <= {1'b0, word[WORD_W-1:1]};
                        end
                    end
                    default: begin
                        half_q     <= 1'b0;
                        stream_err <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/bmc_edge_rx.sv
module bmc_edge_rx
    import bmc_rx_pkg::*;
#(
    parameter int TS_W      = 8,
    parameter int SHORT_MAX = 6,
    parameter int LONG_MAX  = 12,
    parameter int WORD_W    = 32,
    parameter int RX_LIMIT  = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              arm,
    input  logic              line_in,
    output logic              bit_valid,
    output logic              bit_value,
    output logic [WORD_W-1:0] bit_word,
    output logic              sync_found,
    output logic              hard_reset,
    output logic              cable_reset,
    output logic              rx_error,
    output logic              rx_timeout
);

    localparam int TMR_W = $clog2(RX_LIMIT + 1);

    rx_state_e           state_q;
    logic [TMR_W-1:0]    tmr_q;
    logic                to_q;
    logic                iv_valid;
    logic [TS_W-1:0]     iv_ticks;
    logic [NUM_SIGS-1:0] hunt_hit;
    logic                hunt_clr;
    logic                in_hunt;
    logic                tmr_done;
    bit_evt_t            dec_evt;
    logic                dec_err;

    bmc_rx_edge_stamp #(.TS_W(TS_W)) stamp_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .line_in   (line_in),
        .stamp_clr (state_q == ST_IDLE),
        .iv_valid  (iv_valid),
        .iv_ticks  (iv_ticks)
    );

    assign in_hunt  = (state_q == ST_HUNT);
    assign hunt_clr = !in_hunt || (|hunt_hit);

    bmc_rx_hunt #(.TS_W(TS_W), .SHORT_MAX(SHORT_MAX)) hunt_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (hunt_clr),
        .iv_valid (iv_valid),
        .iv_ticks (iv_ticks),
        .hit      (hunt_hit)
    );

    assign sync_found  = in_hunt && hunt_hit[HIT_SYNC];
    assign hard_reset  = in_hunt && hunt_hit[HIT_HARD];
    assign cable_reset = in_hunt && hunt_hit[HIT_CABLE];

    bmc_rx_bitdec #(
        .TS_W(TS_W), .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX), .WORD_W(WORD_W)
    ) dec_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (state_q != ST_DATA),
        .word_clr   (sync_found),
        .iv_valid   (iv_valid),
        .iv_ticks   (iv_ticks),
        .evt        (dec_evt),
        .word       (bit_word),
        .stream_err (dec_err)
    );

    assign bit_valid  = dec_evt.valid;
    assign bit_value  = dec_evt.value;
    assign rx_error   = dec_err;
    assign rx_timeout = to_q;
    assign tmr_done   = (state_q == ST_DATA) && tick_en && (tmr_q == TMR_W'(RX_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            to_q    <= 1'b0;
        end else begin
            to_q <= arm && tmr_done;
            if (state_q != ST_DATA || !arm) tmr_q <= '0;
            else if (tick_en)               tmr_q <= tmr_q + 1'b1;
            if (!arm) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: state_q <= ST_HUNT;
                    ST_HUNT: if (sync_found) state_q <= ST_DATA;
                    ST_DATA: if (dec_err || tmr_done) state_q <= ST_HUNT;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/bmc_edge_rx_chk.sv
module bmc_edge_rx_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              arm,
    input logic              bit_valid,
    input logic              bit_value,
    input logic [WORD_W-1:0] bit_word,
    input logic              sync_found,
    input logic              hard_reset,
    input logic              cable_reset,
    input logic              rx_error,
    input logic              rx_timeout
);

    AST_ONE_SIGNATURE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sync_found, hard_reset, cable_reset})); // R8

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sync_found |=> !sync_found); // R8

    AST_BIT_OR_ERROR: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && rx_error)); // R5

    AST_WORD_SHIFT: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> (bit_word == {bit_value, $past(bit_word[WORD_W-1:1])})); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!arm && !$past(arm) && !$past(arm, 2)) |->
        !(bit_valid || sync_found || hard_reset || cable_reset || rx_error || rx_timeout)); // R12

    AST_ERR_ARMED: assert property (@(posedge clk) disable iff (rst)
        rx_error |-> $past(arm, 2)); // R12

endmodule

bind bmc_edge_rx bmc_edge_rx_chk #(.WORD_W(WORD_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .arm         (arm),
    .bit_valid   (bit_valid),
    .bit_value   (bit_value),
    .bit_word    (bit_word),
    .sync_found  (sync_found),
    .hard_reset  (hard_reset),
    .cable_reset (cable_reset),
    .rx_error    (rx_error),
    .rx_timeout  (rx_timeout)
);

// File: tb/bmc_edge_rx_tb_top.sv
module bmc_edge_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 32;
    localparam int LIMIT      = 600;
    localparam int WATCHDOG   = 150000;

    localparam logic [31:0] P_SYNC  = 32'h36DB6DB6;
    localparam logic [31:0] P_HARD  = 32'hF33F3F3F;
    localparam logic [31:0] P_CABLE = 32'h3C7FE0FF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en;
    logic arm = 1'b0;
    logic line_in = 1'b0;
    logic bit_valid, bit_value, sync_found, hard_reset, cable_reset, rx_error, rx_timeout;
    logic [WORD_W-1:0] bit_word;

    logic tick_div2 = 1'b0;
    logic tick_ph   = 1'b0;
    int   scale     = 1;

    int n_checks = 0;
    int n_errors = 0;
    int n_bits, n_sync, n_hard, n_cable, n_err, n_to;
    logic [63:0] bits_seen;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) tick_ph <= ~tick_ph;
    assign tick_en = !tick_div2 || tick_ph;

    bmc_edge_rx #(.WORD_W(WORD_W), .RX_LIMIT(LIMIT)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .arm         (arm),
        .line_in     (line_in),
        .bit_valid   (bit_valid),
        .bit_value   (bit_value),
        .bit_word    (bit_word),
        .sync_found  (sync_found),
        .hard_reset  (hard_reset),
        .cable_reset (cable_reset),
        .rx_error    (rx_error),
        .rx_timeout  (rx_timeout)
    );

    // event monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid) begin
                if (n_bits < 64) bits_seen[n_bits] = bit_value;
                n_bits++;
            end
            if (sync_found)  n_sync++;
            if (hard_reset)  n_hard++;
            if (cable_reset) n_cable++;
            if (rx_error)    n_err++;
            if (rx_timeout)  n_to++;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_bits = 0; n_sync = 0; n_hard = 0; n_cable = 0; n_err = 0; n_to = 0;
        bits_seen = '0;
    endtask

    task automatic hold(input int d);
        line_in = ~line_in;
        repeat (d * scale) @(negedge clk);
    endtask

    task automatic hold_glitch(input int d);
        line_in = ~line_in;
        repeat (3) @(negedge clk);
        line_in = ~line_in;
        @(negedge clk);
        line_in = ~line_in;
        repeat (d - 4) @(negedge clk);
    endtask

    task automatic rearm();
        arm = 1'b0;
        repeat (4) @(negedge clk);
        arm = 1'b1;
        repeat (2) @(negedge clk);
        clear_counts();
    endtask

    task automatic send_pattern(input logic [31:0] p);
        for (int i = 0; i < 32; i++) hold(p[i] ? 4 : 8);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            if (b[i]) begin hold(4); hold(4); end
            else hold(8);
        end
    endtask

    task automatic t_reset_state();
        chk("R12 reset bit_valid", bit_valid, 0);
        chk("R12 reset word", bit_word, 0);
        chk("R12 reset pulses", {sync_found, hard_reset, cable_reset, rx_error, rx_timeout}, 0);
    endtask

    task automatic t_sync_byte();
        rearm();
        send_pattern(P_SYNC);
        send_byte(8'hA5);
        hold(20);
        chk("R8 sync count", n_sync, 1);
        chk("R4 bit count", n_bits, 8);
        chk("R4 bits", bits_seen[7:0], 8'hA5);
        chk("R7 word top byte", bit_word[31:24], 8'hA5);
        chk("R5 no error", n_err, 0);
    endtask

    task automatic t_hard();
        rearm();
        send_pattern(P_HARD);
        hold(20);
        chk("R9 hard count", n_hard, 1);
        chk("R9 no sync", n_sync + n_cable, 0);
        send_pattern(P_SYNC);
        hold(20);
        chk("R9 sync after hard", n_sync, 1);
    endtask

    task automatic t_cable();
        rearm();
        send_pattern(P_CABLE);
        hold(20);
        chk("R10 cable count", n_cable, 1);
        chk("R10 no other", n_sync + n_hard, 0);
    endtask

    task automatic t_thresholds();
        rearm();
        send_pattern(P_SYNC);
        hold(6); hold(6); hold(7); hold(12);
        hold(20);
        chk("R3 bit count", n_bits, 3);
        chk("R3 bits 6/6,7,12", bits_seen[2:0], 3'b001);
        chk("R3 no error", n_err, 0);
    endtask

    task automatic t_too_long();
        rearm();
        send_pattern(P_SYNC);
        hold(13);
        hold(20);
        chk("R6 over limit error", n_err, 1);
        chk("R6 no bit", n_bits, 0);
    endtask

    task automatic t_short_long();
        rearm();
        send_pattern(P_SYNC);
        hold(4); hold(8);
        hold(20);
        chk("R5 short-long error", n_err, 1);
        chk("R5 no bit", n_bits, 0);
        // R13: fresh preamble end after error
        clear_counts();
        send_pattern(P_SYNC);
        send_byte(8'h3C);
        hold(20);
        chk("R13 resync after error", n_sync, 1);
        chk("R13 bits after error", bits_seen[7:0], 8'h3C);
    endtask

    task automatic t_zero();
        rearm();
        send_pattern(P_SYNC);
        hold(256);
        hold(20);
        chk("R6 zero interval error", n_err, 1);
        chk("R2 wrap no bit", n_bits, 0);
    endtask

    task automatic t_timeout();
        rearm();
        send_pattern(P_SYNC);
        hold(LIMIT + 100);
        chk("R11 timeout count", n_to, 1);
        chk("R11 no error", n_err, 0);
        clear_counts();
        hold(20);
        send_pattern(P_SYNC);
        send_byte(8'h81);
        hold(20);
        chk("R13 resync after timeout", n_sync, 1);
        chk("R13 bits after timeout", bits_seen[7:0], 8'h81);
    endtask

    task automatic t_glitch();
        rearm();
        send_pattern(P_SYNC);
        hold_glitch(8);
        hold(4); hold(4);
        hold(20);
        chk("R1 glitch bits", n_bits, 2);
        chk("R1 glitch values", bits_seen[1:0], 2'b10);
        chk("R1 glitch no error", n_err, 0);
    endtask

    task automatic t_disarmed();
        logic [WORD_W-1:0] w0;
        rearm();
        send_pattern(P_SYNC);
        send_byte(8'h5A);
        hold(20);
        arm = 1'b0;
        repeat (4) @(negedge clk);
        clear_counts();
        w0 = bit_word;
        send_pattern(P_SYNC);
        send_byte(8'hFF);
        hold(20);
        chk("R12 disarmed pulses", n_sync + n_hard + n_cable + n_err + n_to, 0);
        chk("R12 disarmed bits", n_bits, 0);
        chk("R12 word unchanged", bit_word, w0);
    endtask

    task automatic t_tick_div();
        tick_div2 = 1'b1;
        scale = 2;
        rearm();
        send_pattern(P_SYNC);
        send_byte(8'h96);
        hold(20);
        chk("R2 half-rate sync", n_sync, 1);
        chk("R2 half-rate bits", bits_seen[7:0], 8'h96);
        chk("R2 half-rate no error", n_err, 0);
        tick_div2 = 1'b0;
        scale = 1;
    endtask

    initial begin
        clear_counts();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_sync_byte();
        t_hard();
        t_cable();
        t_thresholds();
        t_too_long();
        t_short_long();
        t_zero();
        t_timeout();
        t_glitch();
        t_disarmed();
        t_tick_div();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule